// File: doc/BRIEF.md
# Auto-Reload Decrementer Timer

This block is a down-counting timer that advances on the same single-cycle tick enable that paces the processor time base. Software loads a start value into the count register. Each tick lowers the count by one. The tick that takes the count from one to zero is the expiry event, and it sets a sticky expiry flag in the status register.

If auto-reload is enabled when the expiry happens, the counter restarts from a separate reload register and so produces a periodic event. If auto-reload is off, the counter stays at zero until software loads a new value.

The interrupt output is a level signal. It is the AND of the expiry flag and an interrupt-enable bit in the control register. Software clears the flag by writing a one to its bit in the status register. All registers sit behind a simple register port with one write channel and one independent read address.

Top module: `dec_timer_unit`

## Requirements
- R1: After reset the count, the control register and the status register read zero, and `irq_o` is low.
- R2: On a clock edge with `tick_en` high and a nonzero count, and no count write, the count drops by exactly one. Without `tick_en` the count does not change.
- R3: A tick that finds the count at one is an expiry. It sets status bit 27 on that edge.
- R4: If control bit 22 (auto-reload enable) is one at an expiry, the count is loaded with the reload register value instead of zero.
- R5: If control bit 22 is zero at an expiry, the count becomes zero. Further ticks leave it at zero and do not set the flag again. A later write of a nonzero count restarts the countdown.
- R6: A write to the count register (address 0) overrides a decrement or reload on the same edge. The written value is loaded and no expiry happens on that edge.
- R7: A write to the status register (address 3) clears each implemented bit written as one and leaves bits written as zero unchanged. An expiry on the same edge as a clearing write leaves bit 27 set.
- R8: `irq_o` is high exactly when status bit 27 and control bit 26 (interrupt enable) are both one. It follows a change of either bit with no further delay.
- R9: The control register (address 2) keeps only bits 26 and 22. The status register keeps only bit 27. All other bits of both registers read zero.
- R10: Address map: 0 count (read/write), 1 reload (write-only, reads zero), 2 control, 3 status. Reads are combinational on `reg_raddr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Time-base tick enable, one cycle per tick |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 2 | Write address |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 2 | Read address |
| reg_rdata | output | 32 | Read data for `reg_raddr` |
| irq_o | output | 1 | Level interrupt |

## Verification
Two pairs of events can land on the same edge. The first pair is a software count write and an expiring tick. The second pair is an expiry and a status write that clears the flag. The bench forces each pair on purpose, with the count at one and `tick_en` raised in the cycle of the write. It also lets them meet by chance in a random phase that keeps counts and reload values small. A behavioural model decides each edge with write-wins for the count and set-wins for the flag, and every register and the interrupt are compared with the model on each cycle.

// File: rtl/dec_timer_pkg.sv
package dec_timer_pkg;
   localparam int DT_DATA_W   = 32;
   localparam int ST_EXP_BIT  = 27;
   localparam int CTL_IE_BIT  = 26;
   localparam int CTL_ARE_BIT = 22;

   typedef enum logic [1:0] {
      SEL_COUNT  = 2'd0,
      SEL_RELOAD = 2'd1,
      SEL_CTRL   = 2'd2,
      SEL_STAT   = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/dec_count_core.sv
module dec_count_core #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             ld_i,
   input  logic [CNT_W-1:0] ld_val_i,
   input  logic             reload_wr_i,
   input  logic [CNT_W-1:0] reload_val_i,
   input  logic             are_i,
   output logic [CNT_W-1:0] count_o,
   output logic [CNT_W-1:0] reload_o,
   output logic             expire_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] count_q, count_d, reload_q;
   logic             at_one, at_zero;

   assign at_one   = (count_q == ONE);
   assign at_zero  = (count_q == '0);
   assign expire_o = tick_i && !ld_i && at_one;

   always_comb begin
      count_d = count_q;
      if (ld_i)
         count_d = ld_val_i;
      else if (tick_i && !at_zero) begin
         if (at_one)
            count_d = are_i ? reload_q : '0;
         else
            count_d = count_q - ONE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q  <= '0;
         reload_q <= '0;
      end else begin
         count_q <= count_d;
         if (reload_wr_i)
            reload_q <= reload_val_i;
      end
   end

   assign count_o  = count_q;
   assign reload_o = reload_q;

   assert_decrement_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !ld_i && count_q > ONE) |=> (count_q == $past(count_q) - ONE));
   assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !ld_i) |=> $stable(count_q));
   assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (expire_o && are_i) |=> (count_q == $past(reload_q)));
   assert_hold_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_i && at_zero) |=> (count_q == '0));
   assert_write_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ld_i |=> (count_q == $past(ld_val_i)));
endmodule

// File: rtl/dec_ctrl_stat.sv
module dec_ctrl_stat
   import dec_timer_pkg::*;
#(
   parameter int DATA_W = DT_DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr_i,
   input  logic              stat_wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              expire_i,
   output logic [DATA_W-1:0] ctl_o,
   output logic [DATA_W-1:0] stat_o,
   output logic              are_o,
   output logic              irq_o
);
   localparam logic [DATA_W-1:0] CTL_MASK =
      (DATA_W'(1) << CTL_IE_BIT) | (DATA_W'(1) << CTL_ARE_BIT);
   localparam logic [DATA_W-1:0] ST_MASK  = DATA_W'(1) << ST_EXP_BIT;

   logic [DATA_W-1:0] ctl_q, stat_q, stat_d, clr_bits, set_bits;

   assign clr_bits = stat_wr_i ? (wdata_i & ST_MASK) : '0;
   assign set_bits = expire_i ? ST_MASK : '0;
   assign stat_d   = (stat_q & ~clr_bits) | set_bits;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q  <= '0;
         stat_q <= '0;
      end else begin
         if (ctl_wr_i)
            ctl_q <= wdata_i & CTL_MASK;
         stat_q <= stat_d;
      end
   end

   assign ctl_o  = ctl_q;
   assign stat_o = stat_q;
   assign are_o  = ctl_q[CTL_ARE_BIT];
   assign irq_o  = stat_q[ST_EXP_BIT] & ctl_q[CTL_IE_BIT];

   assert_expire_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
      expire_i |=> stat_q[ST_EXP_BIT]);
   assert_w1c_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr_i && wdata_i[ST_EXP_BIT] && !expire_i) |=> !stat_q[ST_EXP_BIT]);
   assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q[ST_EXP_BIT] && !(stat_wr_i && wdata_i[ST_EXP_BIT])) |=> stat_q[ST_EXP_BIT]);
   assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> ($rose(stat_q[ST_EXP_BIT]) || $rose(ctl_q[CTL_IE_BIT])));
   assert_unused_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(ctl_q) <= 2) && ($countones(stat_q) <= 1));
endmodule

// File: rtl/dec_timer_unit.sv
module dec_timer_unit
   import dec_timer_pkg::*;
#(
   parameter int CNT_W           = 32,
   parameter int DATA_W          = DT_DATA_W,
   parameter bit RELOAD_READABLE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              reg_wr,
   input  logic [1:0]        reg_waddr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic [1:0]        reg_raddr,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq_o
);
   generate
      if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt_w
         $error("CNT_W must lie between 2 and DATA_W");
      end
      if (DATA_W <= ST_EXP_BIT) begin : g_bad_data_w
         $error("DATA_W too narrow for the status and control layout");
      end
   endgenerate

   logic              wr_count, wr_reload, wr_ctrl, wr_stat;
   logic              are, expire;
   logic [CNT_W-1:0]  count, reload;
   logic [DATA_W-1:0] ctl, stat, reload_rd;

   assign wr_count  = reg_wr && (reg_waddr == SEL_COUNT);
   assign wr_reload = reg_wr && (reg_waddr == SEL_RELOAD);
   assign wr_ctrl   = reg_wr && (reg_waddr == SEL_CTRL);
   assign wr_stat   = reg_wr && (reg_waddr == SEL_STAT);

   dec_count_core #(.CNT_W(CNT_W)) u_core (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick_i       (tick_en),
      .ld_i         (wr_count),
      .ld_val_i     (reg_wdata[CNT_W-1:0]),
      .reload_wr_i  (wr_reload),
      .reload_val_i (reg_wdata[CNT_W-1:0]),
      .are_i        (are),
      .count_o      (count),
      .reload_o     (reload),
      .expire_o     (expire)
   );

   dec_ctrl_stat #(.DATA_W(DATA_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_wr_i  (wr_ctrl),
      .stat_wr_i (wr_stat),
      .wdata_i   (reg_wdata),
      .expire_i  (expire),
      .ctl_o     (ctl),
      .stat_o    (stat),
      .are_o     (are),
      .irq_o     (irq_o)
   );

   generate
      if (RELOAD_READABLE) begin : g_reload_rd
         assign reload_rd = DATA_W'(reload);
      end else begin : g_reload_wo
         logic reload_unused;
         assign reload_unused = ^reload;
         assign reload_rd     = DATA_W'(reload_unused & 1'b0);
      end
   endgenerate

   always_comb begin
      unique case (reg_sel_e'(reg_raddr))
         SEL_COUNT:  reg_rdata = DATA_W'(count);
         SEL_RELOAD: reg_rdata = reload_rd;
         SEL_CTRL:   reg_rdata = ctl;
         default:    reg_rdata = stat;
      endcase
   end

   assert_reset_state_R1: assert property (@(posedge clk)
      !rst_n |=> (count == '0 && ctl == '0 && stat == '0));
   assert_no_expire_on_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_count |-> !expire);
endmodule

// File: tb/dec_timer_unit_tb.sv
`timescale 1ns/1ps
module dec_timer_unit_tb;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_waddr = 2'd0;
   logic [31:0] reg_wdata = 32'd0;
   logic [1:0]  reg_raddr = 2'd0;
   logic [31:0] reg_rdata;
   logic        irq_o;

   int n_cmp = 0;
   int n_bad = 0;
   int cycles = 0;
   bit done = 1'b0;

   logic [31:0] m_cnt = 0, m_rel = 0, m_ctl = 0, m_st = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dec_timer_unit u_dut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_wr(reg_wr),
      .reg_waddr(reg_waddr), .reg_wdata(reg_wdata), .reg_raddr(reg_raddr),
      .reg_rdata(reg_rdata), .irq_o(irq_o)
   );

   // Reference model, one update per edge
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt = 0; m_rel = 0; m_ctl = 0; m_st = 0;
      end else begin
         logic [31:0] nc;
         bit ex;
         ex = 0;
         nc = m_cnt;
         if (reg_wr && reg_waddr == 2'd0) nc = reg_wdata;              // R6
         else if (tick_en && m_cnt != 0) begin
            if (m_cnt == 1) begin
               ex = 1;                                                  // R3
               nc = m_ctl[22] ? m_rel : 32'd0;                          // R4 R5
            end else nc = m_cnt - 1;                                    // R2
         end
         if (reg_wr && reg_waddr == 2'd1) m_rel = reg_wdata;
         if (reg_wr && reg_waddr == 2'd2) m_ctl = reg_wdata & 32'h0440_0000; // R9
         if (reg_wr && reg_waddr == 2'd3) m_st = m_st & ~(reg_wdata & 32'h0800_0000); // R7
         if (ex) m_st[27] = 1'b1;
         m_cnt = nc;
      end
   end

   task automatic cmp(input logic [31:0] act, input logic [31:0] exp, input string req);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s at cycle %0d: actual %h expected %h", req, cycles, act, exp);
      end
   endtask

   // Compare every register and the interrupt on each falling edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         cycles++;
         reg_raddr = 2'd0; #1 cmp(reg_rdata, m_cnt, "R2/R4/R5/R6 count");
         reg_raddr = 2'd1; #1 cmp(reg_rdata, 32'd0, "R10 reload reads zero");
         reg_raddr = 2'd2; #1 cmp(reg_rdata, m_ctl, "R9 control");
         reg_raddr = 2'd3; #1 cmp(reg_rdata, m_st, "R3/R7 status");
         cmp({31'd0, irq_o}, {31'd0, m_st[27] & m_ctl[26]}, "R8 irq");
      end
   end

   task automatic drive(input bit t, input bit w, input logic [1:0] a, input logic [31:0] d);
      @(posedge clk); #2;
      tick_en = t; reg_wr = w; reg_waddr = a; reg_wdata = d;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) drive(0, 0, 2'd0, 32'd0);
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) drive(1, 0, 2'd0, 32'd0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      // R1: reset state, checked by the first compares
      @(negedge clk); #5;
      cmp({31'd0, irq_o}, 32'd0, "R1 irq after reset");
      // R2: countdown with gaps in the tick
      drive(0, 1, 2'd0, 32'd5);
      drive(1, 0, 2'd0, 0); drive(0, 0, 2'd0, 0); drive(1, 0, 2'd0, 0);
      idle(3); ticks(2);
      // R3 R5: expiry without auto-reload, then hold at zero
      ticks(4); idle(2);
      // R8: irq rises when enable set, R9: only bits 26 and 22 kept
      drive(0, 1, 2'd2, 32'hFFFF_FFFF); idle(1);
      drive(0, 1, 2'd2, 32'h0400_0000); idle(1);
      // R7: a write of zeros leaves the flag, a write of one clears it
      drive(0, 1, 2'd3, 32'hF7FF_FFFF); idle(1);
      drive(0, 1, 2'd3, 32'h0800_0000); idle(1);
      // R5: a new nonzero write restarts
      drive(0, 1, 2'd0, 32'd2); ticks(3);
      // R4: periodic reload; R10: reload is write-only
      drive(0, 1, 2'd1, 32'd3);
      drive(0, 1, 2'd2, 32'h0440_0000);
      drive(0, 1, 2'd0, 32'd2);
      ticks(10);
      // R7: clear on the same edge as an expiry keeps the flag
      drive(0, 1, 2'd0, 32'd1);
      drive(1, 1, 2'd3, 32'h0800_0000); idle(2);
      // R6: count write on the same edge as an expiring tick
      drive(0, 1, 2'd3, 32'h0800_0000);
      drive(0, 1, 2'd0, 32'd1);
      drive(1, 1, 2'd0, 32'd7); idle(2); ticks(3);
      // Mixed random traffic with small values to provoke collisions
      for (int i = 0; i < 1500; i++) begin
         logic [1:0] a;
         logic [31:0] d;
         a = 2'($urandom_range(0, 3));
         d = (a == 2'd0 || a == 2'd1) ? 32'($urandom_range(0, 4)) : $urandom;
         drive(1'($urandom_range(0, 1)), ($urandom_range(0, 5) == 0), a, d);
      end
      idle(3);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * WATCHDOG);
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule